// File: doc/BRIEF.md
# Serial-Programmed Clock Fan-Out Enable Controller

This block sits beside a one-input, five-output clock fan-out. It sets which of the five copies of the input clock are allowed to toggle. A host programs it over a two-wire serial bus (SCL clock, SDA open-drain data). The block only ever receives. It detects START and STOP, matches a fixed 7-bit device address with the write direction, and acknowledges each byte in the ninth clock.

After the address, the host must send two preamble bytes: a command code and a byte count. Both are acknowledged, but their contents are ignored. The next two bytes are control bytes, and they are loaded by position only. The first one written holds the enables of outputs 0 to 3. The second holds the enable of output 4. Any further bytes are acknowledged and dropped. Nothing can be read back.

SCL and SDA are sampled by a system clock through two-flop synchronisers, then edge-detected. Each gated clock output is the input clock ANDed with an enable bit. That enable bit is retimed so it only changes while the input clock is low, so a disabled output sits low and an enable change never cuts a pulse short.

Top module: `clkfan_ctl`

## Requirements
- R1: After reset all five enable bits are 1, all five gated clocks follow the input clock, and SDA is not pulled low.
- R2: Only the address byte 0xD2 (device address 1101001, direction bit 0 = write) is acknowledged. Any other first byte, including the read request 0xD3, gets no acknowledge. Later bytes of that transfer get no acknowledge and change no enable.
- R3: For the address and every later byte of an addressed transfer, SDA is pulled low during the ninth SCL high phase and released after the following SCL fall. Data is taken MSB first on the rising SCL.
- R4: A falling SDA while SCL is high (START) restarts address reception, even in the middle of a transfer. A rising SDA while SCL is high (STOP) ends the transfer.
- R5: The two bytes that follow the address are acknowledged, and their contents never change an enable, whatever their value.
- R6: The third byte after the address is control byte 0: bit 0 sets output 0, bit 1 sets output 1, bit 6 sets output 2 and bit 7 sets output 3. Bits 5..2 have no effect. A bit value of 1 enables the output.
- R7: The fourth byte after the address is control byte 1: bit 0 sets output 4. Bits 7..1 have no effect.
- R8: Bytes after control byte 1 are acknowledged and change no enable.
- R9: A STOP before control byte 1 leaves output 4's enable unchanged. Enables already written keep their new values.
- R10: A disabled output stays low. An enabled output is a non-inverted copy of the input clock.
- R11: A gated output rises only together with a rising input clock and falls only together with a falling input clock, so no truncated pulse appears.
- R12: The enable outputs change on the third system-clock rising edge after SCL is presented high for the last bit of a control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line, as seen on the wire |
| sda_low_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| ref_clk_i | input | 1 | Clock to be fanned out |
| en_o | output | 5 | Current enable of each output, bit i for output i |
| clk_o | output | 5 | Gated copies of ref_clk_i, bit i for output i |

## Verification
The bench builds the block with its default parameters: device address 0x69, two preamble bytes, two-stage bus synchronisers and two-stage gate retiming. With a two-stage bus synchroniser, the enable update falls on a fixed third system edge, so the reference model can compare the enables on every clock. The two-byte preamble puts control byte 0 at position three and control byte 1 at position four. This lets the tests cover a discarded preamble, an early STOP, trailing bytes, a repeated START and a read request. A reference clock that is asynchronous to the system clock, with a period that is not a multiple of it, makes enable changes land at many phases of the reference clock. That exercises the no-runt rule.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/1ps
package clkfan_pkg;

  // number of gated clock outputs
  localparam int unsigned N_OUT = 5;

  // for output i: which control byte (0 or 1) and which bit of it carries its enable
  localparam int unsigned MAP_BYTE [N_OUT] = '{0, 0, 0, 0, 1};
  localparam int unsigned MAP_BIT  [N_OUT] = '{0, 1, 6, 7, 0};

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_ACK   = 2'd2,
    RX_SKIP  = 2'd3
  } rx_state_t;

endpackage

// File: rtl/clkfan_sync.sv
`timescale 1ns/1ps
module clkfan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] scl_sh;
  logic [TOP:0] sda_sh;
  logic         scl_q;
  logic         sda_q;

  // idle bus is high, so the chains reset to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_raw};
      sda_sh <= {sda_sh[TOP-1:0], sda_raw};
      scl_q  <= scl_sh[TOP];
      sda_q  <= sda_sh[TOP];
    end
  end

  always_comb begin
    scl_lvl   = scl_sh[TOP];
    sda_lvl   = sda_sh[TOP];
    scl_rise  = scl_lvl & ~scl_q;
    scl_fall  = ~scl_lvl & scl_q;
    start_det = sda_q & ~sda_lvl & scl_lvl & scl_q;
    stop_det  = ~sda_q & sda_lvl & scl_lvl & scl_q;
  end

endmodule

// File: rtl/clkfan_rx.sv
`timescale 1ns/1ps
module clkfan_rx
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         IDX_W    = 3,
  parameter int         IDX_MAX  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_low_o,
  output logic             stb_o,
  output logic [7:0]       byte_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [7:0]       WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(IDX_MAX);

  rx_state_t        state;
  logic [3:0]       bit_cnt;
  logic [6:0]       shreg;
  logic [IDX_W-1:0] byte_idx;
  logic             ack_ok;
  logic             drive;
  logic [7:0]       full_byte;
  logic             last_bit;

  always_comb begin
    full_byte = {shreg, sda_lvl};
    last_bit  = (state == RX_SHIFT) && scl_rise && (bit_cnt == 4'd7);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      ack_ok   <= 1'b0;
      drive    <= 1'b0;
    end else if (start_det) begin
      state    <= RX_SHIFT;
      bit_cnt  <= '0;
      byte_idx <= '0;
      ack_ok   <= 1'b0;
      drive    <= 1'b0;
    end else if (stop_det) begin
      state <= RX_IDLE;
      drive <= 1'b0;
    end else begin
      case (state)
        RX_SHIFT: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= full_byte[6:0];
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == 4'd7) begin
              ack_ok <= (byte_idx != '0) || (full_byte == WR_ADDR);
            end
          end else if (scl_fall && bit_cnt == 4'd8) begin
            if (ack_ok) begin
              state <= RX_ACK;
              drive <= 1'b1;
            end else begin
              state <= RX_SKIP;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            drive    <= 1'b0;
            state    <= RX_SHIFT;
            bit_cnt  <= '0;
            byte_idx <= (byte_idx == IDX_TOP) ? byte_idx : byte_idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sda_low_o = drive;
    stb_o     = last_bit && (byte_idx != '0);
    byte_o    = full_byte;
    idx_o     = byte_idx;
  end

  // R3: the acknowledge drive is only switched on while SCL is low
  p_ack_under_low_scl_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(drive) |-> !scl_lvl);

  // R2: no pull-down while idle or after an address mismatch
  p_quiet_unaddressed_r2: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE || state == RX_SKIP) |-> !drive);

  // R4: a START always brings reception back to the address byte
  p_start_restarts_r4: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == RX_SHIFT && bit_cnt == 4'd0 && byte_idx == '0));

endmodule

// File: rtl/clkfan_enreg.sv
`timescale 1ns/1ps
module clkfan_enreg
  import clkfan_pkg::*;
#(
  parameter int PRE_BYTES = 2,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  logic [7:0]       byte_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_OUT-1:0] en_o
);

  localparam int LAST_CTRL = PRE_BYTES + 2;

  logic [N_OUT-1:0] en_q;

  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    localparam int unsigned SEL_IDX = PRE_BYTES + 1 + MAP_BYTE[i];
    localparam int unsigned SEL_BIT = MAP_BIT[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i] <= 1'b1;
      end else if (stb_i && idx_i == IDX_W'(SEL_IDX)) begin
        en_q[i] <= byte_i[SEL_BIT[2:0]];
      end
    end
  end

  assign en_o = en_q;

  // R8: without a byte strobe the enables hold
  p_hold_without_byte_r8: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> $stable(en_q));

  // R8: bytes past the last control byte change nothing
  p_tail_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (stb_i && idx_i > IDX_W'(LAST_CTRL)) |=> $stable(en_q));

  // R5: preamble bytes change nothing
  p_preamble_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (stb_i && idx_i <= IDX_W'(PRE_BYTES)) |=> $stable(en_q));

endmodule

// File: rtl/clkfan_gate.sv
`timescale 1ns/1ps
module clkfan_gate
  import clkfan_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] en_i,
  output logic [N_OUT-1:0] clk_o
);

  // retiming chain clocked on the falling reference edge: the applied
  // enable can only move while the reference clock is low
  logic [N_OUT-1:0] stage [SYNC];

  for (genvar s = 0; s < SYNC; s++) begin : g_stage
    always_ff @(negedge ref_clk) begin
      if (rst) begin
        stage[s] <= '1;
      end else if (s == 0) begin
        stage[s] <= en_i;
      end else begin
        stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign clk_o = {N_OUT{ref_clk}} & stage[SYNC-1];

endmodule

// File: rtl/clkfan_ctl.sv
`timescale 1ns/1ps
module clkfan_ctl
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         PRE_BYTES   = 2,
  parameter int         SYNC_STAGES = 2,
  parameter int         GATE_SYNC   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_low_o,
  input  logic             ref_clk_i,
  output logic [N_OUT-1:0] en_o,
  output logic [N_OUT-1:0] clk_o
);

  localparam int IDX_MAX = PRE_BYTES + 3;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);

  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             stb;
  logic [7:0]       rx_byte;
  logic [IDX_W-1:0] rx_idx;

  clkfan_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  clkfan_rx #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W), .IDX_MAX(IDX_MAX)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_low_o (sda_low_o),
    .stb_o     (stb),
    .byte_o    (rx_byte),
    .idx_o     (rx_idx)
  );

  clkfan_enreg #(.PRE_BYTES(PRE_BYTES), .IDX_W(IDX_W)) u_en (
    .clk    (clk),
    .rst    (rst),
    .stb_i  (stb),
    .byte_i (rx_byte),
    .idx_i  (rx_idx),
    .en_o   (en_o)
  );

  clkfan_gate #(.SYNC(GATE_SYNC)) u_gate (
    .ref_clk (ref_clk_i),
    .rst     (rst),
    .en_i    (en_o),
    .clk_o   (clk_o)
  );

endmodule

// File: tb/sim_clkfan_ctl.sv
`timescale 1ns/1ps
module sim_clkfan_ctl;

  localparam int Q   = 12;
  localparam int PRE = 2;

  logic       clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_b = 1'b1;
  logic       sda_b = 1'b1;
  logic       sda_low;
  logic       sda_line;
  logic [4:0] en;
  logic [4:0] gclk;

  assign sda_line = sda_b & ~sda_low;

  clkfan_ctl #(.PRE_BYTES(PRE)) u0 (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_b),
    .sda_i     (sda_line),
    .sda_low_o (sda_low),
    .ref_clk_i (ref_clk),
    .en_o      (en),
    .clk_o     (gclk)
  );

  always #2.5 clk = ~clk;
  always #18.5 ref_clk = ~ref_clk;

  int         n_cmp = 0;
  int         n_bad = 0;
  int         cyc = 0;
  logic [4:0] exp_en = 5'h1F;
  logic [4:0] model_en = 5'h1F;
  int         due_q[$];
  logic [4:0] val_q[$];
  int         k;
  bit         hit;
  bit         done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // every-clock comparison of the enables against the model (R6 R7 R9 R12)
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      exp_en = val_q.pop_front();
      void'(due_q.pop_front());
    end
    if (cyc >= 2 && !done) chk("R12 en_o per-cycle", en, exp_en);
  end

  // R11: gated edges must coincide with reference edges
  logic [4:0] gprev = '0;
  always @(gclk) begin
    for (int i = 0; i < 5; i++) begin
      if (!rst && !done && gclk[i] !== gprev[i]) begin
        if (gclk[i] === 1'b1) chk("R11 rise with ref", ref_clk, 1);
        else                  chk("R11 fall with ref", ref_clk, 0);
      end
    end
    gprev = gclk;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_b = 1'b1; wq(Q);
    scl_b = 1'b1; wq(Q);
    sda_b = 1'b0; wq(Q);
    scl_b = 1'b0; wq(Q);
    k = 0; hit = 0;
  endtask

  task automatic i2c_stop;
    sda_b = 1'b0; wq(Q);
    scl_b = 1'b1; wq(Q);
    sda_b = 1'b1; wq(Q);
  endtask

  task automatic model_hook(input logic [7:0] b);
    if (hit && k == PRE + 1) begin
      model_en = {model_en[4], b[7], b[6], b[1], b[0]};
      due_q.push_back(cyc + 3); val_q.push_back(model_en);
    end else if (hit && k == PRE + 2) begin
      model_en[4] = b[0];
      due_q.push_back(cyc + 3); val_q.push_back(model_en);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic want;
    for (int i = 7; i >= 0; i--) begin
      sda_b = b[i]; wq(Q);
      scl_b = 1'b1;
      if (i == 0) model_hook(b);
      wq(Q);
      scl_b = 1'b0; wq(Q);
    end
    sda_b = 1'b1; wq(Q);
    scl_b = 1'b1; wq(Q / 2);
    want = (k == 0) ? (b == 8'hD2) : hit;
    if (k == 0) chk("R2 address acknowledge", sda_low, want);
    else        chk("R3 data acknowledge", sda_low, want);
    if (k == 0) hit = want;
    wq(Q / 2);
    scl_b = 1'b0; wq(Q);
    chk("R3 acknowledge released", sda_low, 0);
    k++;
  endtask

  task automatic settle_and_check_clocks(input string tag);
    wait (due_q.size() == 0);
    wq(40);
    @(posedge ref_clk); #3;
    chk({tag, " R10 high phase"}, gclk, exp_en);
    @(negedge ref_clk); #3;
    chk({tag, " R10 low phase"}, gclk, 0);
    wq(1);
  endtask

  task automatic summary;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    wq(20);
    chk("R1 enables in reset", en, 5'h1F);
    chk("R1 no SDA drive in reset", sda_low, 0);
    rst = 1'b0;
    wq(5);
    chk("R1 enables after reset", en, 5'h1F);
    settle_and_check_clocks("R1");

    // R6 R7: clear everything
    i2c_start(); send_byte(8'hD2); send_byte(8'h11); send_byte(8'h22);
    send_byte(8'h00); send_byte(8'h00); i2c_stop();
    settle_and_check_clocks("all off");

    // R6 R7: only mapped bits set
    i2c_start(); send_byte(8'hD2); send_byte(8'hFF); send_byte(8'hFF);
    send_byte(8'hC3); send_byte(8'h01); i2c_stop();
    settle_and_check_clocks("all on");

    // R6 R7: only reserved bits set, mapped bits clear
    i2c_start(); send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h3C); send_byte(8'hFE); i2c_stop();
    settle_and_check_clocks("reserved only");

    // R9: early STOP after control byte 0
    i2c_start(); send_byte(8'hD2); send_byte(8'h5A); send_byte(8'hA5);
    send_byte(8'h81); i2c_stop();
    settle_and_check_clocks("R9 early stop");

    // R5: only the preamble bytes, then STOP
    i2c_start(); send_byte(8'hD2); send_byte(8'hC3); send_byte(8'hC3); i2c_stop();
    settle_and_check_clocks("R5 preamble only");

    // R2: wrong address, then bytes that must be ignored
    i2c_start(); send_byte(8'hA4); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'hFF); send_byte(8'hFF); i2c_stop();
    settle_and_check_clocks("R2 wrong address");

    // R2: read request
    i2c_start(); send_byte(8'hD3); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'hFF); send_byte(8'hFF); i2c_stop();
    settle_and_check_clocks("R2 read request");

    // R8: trailing bytes acknowledged and ignored
    i2c_start(); send_byte(8'hD2); send_byte(8'h01); send_byte(8'h02);
    send_byte(8'h42); send_byte(8'h01); send_byte(8'h00); send_byte(8'hFF);
    send_byte(8'h00); i2c_stop();
    settle_and_check_clocks("R8 trailing");

    // R4: repeated START in mid transfer restarts address reception
    i2c_start(); send_byte(8'hD2); send_byte(8'h55);
    i2c_start(); send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00);
    send_byte(8'h01); send_byte(8'h00); i2c_stop();
    settle_and_check_clocks("R4 repeated start");

    summary();
    $finish;
  end

endmodule